// File: doc/BRIEF.md
# Receive-Side Frame Latency Extractor

This block sits in a 64-bit AXI4-Stream receive path. Every frame passes through it unchanged, with one register stage. On the way it finds the timestamp that the sending side wrote into the frame. It subtracts that value from a free-running timestamp input, which it samples when the frame's first beat is accepted. The difference is the frame's latency.

Three modes choose where the timestamp is read from:
- **Off:** no timestamp is read.
- **Header:** a 16-bit field in the IPv4 header is read, and only when the EtherType marks the frame as IPv4.
- **Fixed:** a 16-bit or 24-bit field at a configurable byte offset is read.

The result leaves on the sideband `m_tuser` of the frame's final beat. It carries a flag that tells whether the frame held a timestamp.

Top module: `rx_latency_extract`

## Requirements
- R1: Each accepted input beat appears once at the output, in order, with the same `tdata` and `tlast`. Frames are whole 64-bit beats.
- R2: A beat offered on the output holds `m_tvalid`, `m_tdata`, `m_tlast` and `m_tuser` steady until `m_tready` is seen. `s_tready` is high whenever the output register is empty or is being drained, so random `m_tready` patterns lose and reorder nothing.
- R3: Frame byte n travels in beat n/8 on bits [8*(n%8)+7 : 8*(n%8)]. A timestamp field is read most significant byte first, starting at its lowest byte address.
- R4: With `mode_i` = 1 (header), a frame whose bytes 12 and 13 are 0x08 and 0x00 is IPv4. Its timestamp is the 16-bit field in bytes 18 and 19, and the latency is computed modulo 2^16.
- R5: In header mode, a frame that is not IPv4 reports no latency.
- R6: With `mode_i` = 0 (or 3), no frame reports a latency.
- R7: With `mode_i` = 2 (fixed), `width_i` = 0 reads 16 bits at bytes `pos_i` and `pos_i`+1. `width_i` = 1 reads 24 bits at bytes `pos_i` to `pos_i`+2. Offsets up to 1518 are allowed, provided the field lies inside one beat.
- R8: The latency is (timestamp at first beat − embedded value) modulo 2^W, with W = 16 or 24, so a counter that wrapped still gives the short interval.
- R9: The timestamp, mode, offset and width are all sampled on the frame's first accepted beat. Changes to them later in the frame have no effect on that frame.
- R10: `m_tuser` = {valid, latency[23:0]} on the last beat of a frame. It is all zero on every other beat and whenever no latency applies. This still holds when the field sits in the last beat.
- R11: A frame that ends before its timestamp field is complete reports no latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 0 off, 1 header, 2 fixed offset |
| pos_i | input | 11 | Byte offset of the field in fixed mode |
| width_i | input | 1 | 0 = 16-bit field, 1 = 24-bit field |
| timestamp_i | input | 24 | Free-running time counter |
| s_tdata | input | 64 | Input stream data |
| s_tvalid | input | 1 | Input beat valid |
| s_tlast | input | 1 | Input beat ends the frame |
| s_tready | output | 1 | Input beat accepted |
| m_tdata | output | 64 | Output stream data |
| m_tvalid | output | 1 | Output beat valid |
| m_tlast | output | 1 | Output beat ends the frame |
| m_tuser | output | 25 | {latency valid, latency} on last beat |
| m_tready | input | 1 | Downstream ready |

## Verification
The frames cover each mode in turn:
- IPv4 and non-IPv4 frames in header mode, which shows that the EtherType test gates the result.
- The same IPv4 frame with the mode set to off.
- Fixed offsets in the first beat, in a middle beat, in the final beat and at offset 1518, with both field widths. These separate lane and beat decoding errors.

Further frames aim at specific rules:
- One frame has a field value above the current timestamp, which exposes missing wraparound.
- Frames that end before their field test R11.
- One frame changes the mode after its first beat, which shows whether settings are sampled at the right moment.
- A single-beat frame tests a field that is read in the same beat as the last one.

The whole set is then replayed under random `m_tready`, which shows whether backpressure loses, repeats or corrupts beats.

// File: rtl/lx_pkg.sv
package lx_pkg;
    typedef enum logic [1:0] {
        LX_OFF = 2'd0,
        LX_HDR = 2'd1,
        LX_FIX = 2'd2
    } lx_mode_e;

    // byte addresses inside an Ethernet/IPv4 frame
    localparam int HDR_TYPE_BYTE = 12;
    localparam int HDR_TS_BYTE   = 18;
    localparam int LAT_W         = 24;
endpackage

// File: rtl/lx_field_pick.sv
module lx_field_pick #(
    parameter int DATA_W = 64,
    localparam int LANES  = DATA_W / 8,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic [DATA_W-1:0] data,
    input  logic [LANE_W-1:0] lane,
    input  logic              wide,
    output logic [23:0]       field
);
    logic [7:0] by [LANES+2];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign by[g] = data[8*g +: 8];
    end
    assign by[LANES]   = 8'h00;
    assign by[LANES+1] = 8'h00;

    always_comb begin
        int li;
        li = int'(lane);
        if (wide) field = {by[li], by[li+1], by[li+2]};
        else      field = {8'h00, by[li], by[li+1]};
    end
endmodule

// File: rtl/lx_lat_calc.sv
module lx_lat_calc (
    input  logic [23:0] now,
    input  logic [23:0] mark,
    input  logic        wide,
    output logic [23:0] lat
);
    logic [23:0] diff;
    assign diff = now - mark;
    assign lat  = wide ? diff : {8'h00, diff[15:0]};
endmodule

// File: rtl/rx_latency_extract.sv
module rx_latency_extract
    import lx_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int POS_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic [POS_W-1:0]  pos_i,
    input  logic              width_i,
    input  logic [LAT_W-1:0]  timestamp_i,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic              s_tvalid,
    input  logic              s_tlast,
    output logic              s_tready,
    output logic [DATA_W-1:0] m_tdata,
    output logic              m_tvalid,
    output logic              m_tlast,
    output logic [LAT_W:0]    m_tuser,
    input  logic              m_tready
);
    localparam int LANES     = DATA_W / 8;
    localparam int LANE_W    = $clog2(LANES);
    localparam int BEAT_W    = POS_W - LANE_W;
    localparam int TYPE_BEAT = HDR_TYPE_BYTE / LANES;
    localparam int TYPE_LANE = HDR_TYPE_BYTE % LANES;
    localparam int TS_BEAT   = HDR_TS_BYTE / LANES;
    localparam int TS_LANE   = HDR_TS_BYTE % LANES;

    typedef struct packed {
        logic [BEAT_W-1:0] beat;
        logic [1:0]        mode;
        logic [POS_W-1:0]  pos;
        logic              wide;
        logic [LAT_W-1:0]  ts;
        logic [LAT_W-1:0]  field;
        logic              hit;
        logic              ip;
        logic              mvalid;
        logic [DATA_W-1:0] mdata;
        logic              mlast;
        logic [LAT_W:0]    muser;
    } st_t;

    st_t st_q, st_d;

    logic              acc, first, hdr, fix, wide_eff, ip_now, at_tgt;
    logic [1:0]        mode_now;
    logic [POS_W-1:0]  pos_now;
    logic              wide_now;
    logic [LAT_W-1:0]  ts_now, picked, field_now, lat;
    logic [BEAT_W-1:0] tgt_beat;
    logic [LANE_W-1:0] tgt_lane;

    assign s_tready = !st_q.mvalid || m_tready;
    assign acc      = s_tvalid && s_tready;
    assign first    = (st_q.beat == '0);
    assign mode_now = first ? mode_i      : st_q.mode;
    assign pos_now  = first ? pos_i       : st_q.pos;
    assign wide_now = first ? width_i     : st_q.wide;
    assign ts_now   = first ? timestamp_i : st_q.ts;
    assign hdr      = (mode_now == LX_HDR);
    assign fix      = (mode_now == LX_FIX);
    assign wide_eff = fix && wide_now;
    assign tgt_beat = hdr ? BEAT_W'(TS_BEAT) : pos_now[POS_W-1:LANE_W];
    assign tgt_lane = hdr ? LANE_W'(TS_LANE) : pos_now[LANE_W-1:0];
    assign ip_now   = st_q.ip ||
                      (st_q.beat == BEAT_W'(TYPE_BEAT) &&
                       s_tdata[8*TYPE_LANE +: 8] == 8'h08 &&
                       s_tdata[8*(TYPE_LANE+1) +: 8] == 8'h00);
    assign at_tgt    = (st_q.beat == tgt_beat) && !st_q.hit && (fix || (hdr && ip_now));
    assign field_now = at_tgt ? picked : st_q.field;

    lx_field_pick #(.DATA_W(DATA_W)) u_pick (
        .data (s_tdata),
        .lane (tgt_lane),
        .wide (wide_eff),
        .field(picked)
    );

    lx_lat_calc u_calc (
        .now (ts_now),
        .mark(field_now),
        .wide(wide_eff),
        .lat (lat)
    );

    always_comb begin
        logic hit_now;
        st_d    = st_q;
        hit_now = st_q.hit || at_tgt;
        if (acc) begin
            st_d.beat  = s_tlast ? '0 : ((&st_q.beat) ? st_q.beat : st_q.beat + 1'b1);
            st_d.mode  = mode_now;
            st_d.pos   = pos_now;
            st_d.wide  = wide_now;
            st_d.ts    = ts_now;
            st_d.field = field_now;
            st_d.hit   = s_tlast ? 1'b0 : hit_now;
            st_d.ip    = s_tlast ? 1'b0 : ip_now;
        end
        if (s_tready) begin
            st_d.mvalid = s_tvalid;
            st_d.mdata  = s_tdata;
            st_d.mlast  = s_tlast;
            st_d.muser  = (s_tvalid && s_tlast && hit_now) ? {1'b1, lat} : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign m_tvalid = st_q.mvalid;
    assign m_tdata  = st_q.mdata;
    assign m_tlast  = st_q.mlast;
    assign m_tuser  = st_q.muser;

    // output beat held under backpressure
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast) && $stable(m_tuser));

    // sideband only carries data on the closing beat
    assert_user_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid && !m_tlast |-> m_tuser == '0);

    // a frame in progress under the off mode never yields a latency
    assert_off_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc && s_tlast && st_q.beat != '0 && st_q.mode != LX_HDR && st_q.mode != LX_FIX
        |=> !m_tuser[LAT_W]);

    // header mode frame already known non-IPv4 past the field beat gives nothing
    assert_nonip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acc && s_tlast && st_q.beat > BEAT_W'(TS_BEAT) && st_q.mode == LX_HDR && !st_q.ip
        |=> m_tuser == '0);
endmodule

// File: tb/rx_latency_extract_bench.sv
module rx_latency_extract_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_i = 2'd0;
    logic [10:0] pos_i = '0;
    logic        width_i = 1'b0;
    logic [23:0] timestamp_i;
    logic [63:0] s_tdata = '0;
    logic        s_tvalid = 1'b0;
    logic        s_tlast = 1'b0;
    logic        s_tready;
    logic [63:0] m_tdata;
    logic        m_tvalid;
    logic        m_tlast;
    logic [24:0] m_tuser;
    logic        m_tready = 1'b1;

    rx_latency_extract u_rx_latency_extract (.*);

    always #5 clk = ~clk;

    logic [23:0] cyc = '0, ts_off = '0;
    always @(posedge clk) cyc <= cyc + 24'd1;
    assign timestamp_i = ts_off + cyc;

    int errors = 0, checks = 0;
    bit rdy_rand = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [7:0] fb [1536];

    logic [63:0] q_data [$];
    logic        q_last [$];
    logic [24:0] q_user [$];
    string       q_tag  [$];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ready toggler
    initial forever begin
        @(negedge clk);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        m_tready = rdy_rand ? lfsr[0] : 1'b1;
    end

    // monitor / scoreboard
    initial begin
        bit held = 0;
        logic [63:0] hd; logic hl; logic [24:0] hu;
        forever begin
            @(negedge clk); #1;
            if (held) begin
                chk(m_tvalid && m_tdata == hd && m_tlast == hl && m_tuser == hu,
                    "R2 hold", {38'h0, m_tuser, m_tlast}, {38'h0, hu, hl});
                held = 0;
            end
            if (rst_n && m_tvalid && !m_tready) begin
                held = 1; hd = m_tdata; hl = m_tlast; hu = m_tuser;
            end
            if (rst_n && m_tvalid && m_tready) begin
                if (q_data.size() == 0) begin
                    chk(0, "R1 unexpected beat", m_tdata, '0);
                end else begin
                    logic [63:0] ed; logic el; logic [24:0] eu; string et;
                    ed = q_data.pop_front(); el = q_last.pop_front();
                    eu = q_user.pop_front(); et = q_tag.pop_front();
                    chk(m_tdata == ed && m_tlast == el, "R1 data/last", m_tdata, ed);
                    if (el) chk(m_tuser == eu, et, {39'h0, m_tuser}, {39'h0, eu});
                    else if (m_tuser != 0) chk(0, "R10 user on inner beat", {39'h0, m_tuser}, 0);
                end
            end
        end
    end

    function automatic logic [24:0] model(int nb, logic [1:0] md, int pos, bit wd, logic [23:0] ts);
        int n = nb * 8;
        logic [23:0] f;
        if (md == 2'd1) begin
            if (n < 20 || fb[12] != 8'h08 || fb[13] != 8'h00) return '0;
            f = {8'h00, fb[18], fb[19]};
            return {1'b1, 8'h00, ts[15:0] - f[15:0]};
        end
        if (md == 2'd2) begin
            if (wd) begin
                if (pos + 3 > n) return '0;
                f = {fb[pos], fb[pos+1], fb[pos+2]};
                return {1'b1, ts - f};
            end
            if (pos + 2 > n) return '0;
            f = {8'h00, fb[pos], fb[pos+1]};
            return {1'b1, 8'h00, ts[15:0] - f[15:0]};
        end
        return '0;
    endfunction

    task automatic fill(input int nb, input int seed, input logic [15:0] etype);
        for (int i = 0; i < nb * 8; i++) fb[i] = 8'(i * 13 + seed);
        fb[12] = etype[15:8];
        fb[13] = etype[7:0];
    endtask

    task automatic send(input int nb, input logic [1:0] md, input int pos, input bit wd,
                        input string tag, input bit flip);
        logic [23:0] tsf = '0;
        for (int b = 0; b < nb; b++) begin
            @(negedge clk);
            if (b == 0) begin mode_i = md; pos_i = 11'(pos); width_i = wd; end
            if (flip && b == 1) begin mode_i = 2'd0; pos_i = '0; width_i = ~wd; end
            s_tvalid = 1'b1;
            s_tlast  = (b == nb - 1);
            for (int l = 0; l < 8; l++) s_tdata[8*l +: 8] = fb[b*8 + l];
            #1;
            while (!s_tready) begin @(negedge clk); #1; end
            if (b == 0) tsf = timestamp_i;
            q_data.push_back(s_tdata);
            q_last.push_back(s_tlast);
            q_user.push_back(s_tlast ? model(nb, md, pos, wd, tsf) : 25'h0);
            q_tag.push_back(tag);
            @(posedge clk);
        end
        @(negedge clk);
        s_tvalid = 1'b0;
        s_tlast  = 1'b0;
    endtask

    task automatic run_all();
        for (int pass = 0; pass < 2; pass++) begin
            rdy_rand = (pass == 1);
            fill(8, 1, 16'h0800); fb[18] = 8'h12; fb[19] = 8'h34;
            send(8, 2'd1, 0, 0, "R4 header IPv4", 0);
            fill(8, 2, 16'h86DD);
            send(8, 2'd1, 0, 0, "R5 header non-IPv4", 0);
            fill(8, 3, 16'h0800);
            send(8, 2'd0, 0, 1, "R6 mode off", 0);
            fill(8, 4, 16'h0800);
            send(8, 2'd3, 40, 0, "R6 mode 3 off", 0);
            fill(16, 5, 16'h0800);
            send(16, 2'd2, 100, 0, "R7 fixed 16-bit mid", 0);
            fill(32, 6, 16'h1234);
            send(32, 2'd2, 205, 1, "R3 R7 fixed 24-bit lane 5", 0);
            fill(8, 7, 16'h0000);
            send(8, 2'd2, 56, 0, "R10 field in last beat", 0);
            fill(8, 8, 16'h0800);
            send(8, 2'd2, 100, 0, "R11 frame ends before field", 0);
            fill(2, 9, 16'h0800);
            send(2, 2'd1, 0, 0, "R11 short header frame", 0);
            fill(4, 10, 16'h0800); fb[0] = 8'hFF; fb[1] = 8'hFF; fb[2] = 8'hF0;
            @(negedge clk); ts_off = 24'd16 - cyc;
            send(4, 2'd2, 0, 1, "R8 wrap 24-bit", 0);
            fill(8, 11, 16'h0800); fb[18] = 8'hFF; fb[19] = 8'hFE;
            send(8, 2'd1, 0, 0, "R8 wrap 16-bit", 0);
            ts_off = 24'h400000;
            fill(8, 12, 16'h0800); fb[18] = 8'h00; fb[19] = 8'h05;
            send(8, 2'd1, 0, 0, "R9 settings sampled on first beat", 1);
            fill(1, 13, 16'h0000);
            send(1, 2'd2, 0, 0, "R9 R10 single-beat frame", 0);
            fill(190, 14, 16'h0800);
            send(190, 2'd2, 1518, 0, "R7 offset 1518", 0);
        end
        while (q_data.size() != 0) @(negedge clk);
        repeat (10) @(negedge clk);
    endtask

    initial begin
        bit timeout = 0;
        repeat (3) @(negedge clk);
        #1;
        chk(!m_tvalid && m_tuser == 0, "R1 reset state", {38'h0, m_tuser, m_tvalid}, 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(s_tready == 1'b1 && !m_tvalid, "R2 ready after reset", {63'h0, s_tready}, 64'h1);
        fork
            run_all();
            begin repeat (150000) @(posedge clk); timeout = 1; end
        join_any
        if (timeout) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule